// File: doc/BRIEF.md
# Line-Scheduled Successive-Cancellation Polar Decoder

This block decodes one length-8 polar codeword at a time using successive cancellation. A start pulse captures eight signed channel log-likelihood ratios together with a mask that marks the frozen bit positions. A fixed schedule then works through the decoding tree one stage per clock cycle. Only one stage is ever active in a cycle. The widest stage updates four nodes, so four processing elements are enough. These four elements are shared by every stage through input and output multiplexers.

Each processing element performs either the min-sum check-node update (f) or the partial-sum-controlled variable-node update (g), and saturates its result. Results are written into a tree of intermediate LLR registers. A g result overwrites the f result of the same node once that f result has been read for the last time. Every stage-0 result is turned into a hard decision at once. The decided bits are re-encoded to produce the partial sums that later g steps at the higher stages consume.

The estimated bits build up on the output bus as they are decided. They stay there after the one-cycle done pulse until the next accepted start.

Top module: `polar_line_decoder`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `bits_o` are all 0. A `start_i` seen while idle loads the LLRs and the mask and clears `bits_o`; `busy_o` is 1 from the next cycle until the last decision.
- R2: `done_o` is high for exactly one cycle, 2N−2 (14) clock edges after the edge that accepted start. `busy_o` falls on that same edge.
- R3: A bit whose `frozen_i` mask bit is 1 is output as 0, whatever the LLRs are.
- R4: An information bit is 1 when its final stage-0 LLR is negative, and 0 when that LLR is zero or positive. LLRs are two's complement; a positive LLR favours bit 0.
- R5: The f update outputs the product of the two input signs times the smaller of the two magnitudes. A zero input counts as positive.
- R6: The g update outputs b+a when the partial sum is 0 and b−a when it is 1. Every node result is saturated to ±(2^(W−1)−1).
- R7: The partial sums used by a g step at stage s are the polar transform of the 2^s bits decided just before the current bit. A noiseless codeword, or one whose LLR signs are all still correct, therefore decodes to its message.
- R8: Bits are decided in index order 0 to 7, on the 3rd, 4th, 6th, 7th, 10th, 11th, 13th and 14th edges after the accepting edge. Each bit appears on `bits_o` at its position (`bits_o[i]` is bit i) from that edge on.
- R9: A `start_i` raised while busy is ignored. Changes on `llr_i` and `frozen_i` at that time do not alter the running decode.
- R10: While idle and without a start, `bits_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Starts a decode when the block is idle |
| llr_i | input | N*W | Channel LLRs; channel k sits in bits [k*W +: W] |
| frozen_i | input | N | Frozen mask; bit i set forces estimate i to 0 |
| bits_o | output | N | Estimated bits; bit i is estimate i |
| done_o | output | 1 | One-cycle pulse after the last decision |
| busy_o | output | 1 | High while a decode is running |

## Verification
The bench builds the block with N = 8 and W = 6. At this size every stage runs both f and g steps, including the single stage-2 g step that overwrites the whole first-level register group. The 6-bit width lets the stimuli drive LLRs at −32 and +31, so saturation appears in the f magnitude and in the g sums. Noiseless codewords for all sixteen messages under the frozen set {0,1,2,4} test the partial-sum re-encoding end to end. Perturbed, zero-valued, fully frozen and fully unfrozen cases test the decision rule and the mask.

// File: rtl/polar_line_pkg.sv
`timescale 1ns/1ps
package polar_line_pkg;

  // Operation applied by the shared processing elements in one cycle
  typedef enum logic {
    OP_F = 1'b0,
    OP_G = 1'b1
  } node_op_e;

endpackage

// File: rtl/polar_line_pe.sv
`timescale 1ns/1ps
module polar_line_pe
  import polar_line_pkg::*;
#(
  parameter int W = 6
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  input  node_op_e            op_i,
  input  logic                ps_i,
  output logic signed [W-1:0] llr_o
);

  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] SAT_HI = XW'((1 << (W - 1)) - 1);
  localparam logic signed [XW-1:0] SAT_LO = -SAT_HI;

  logic signed [XW-1:0] a_x, b_x, abs_a, abs_b, mag, raw;

  always_comb begin
    a_x   = {{2{a_i[W-1]}}, a_i};
    b_x   = {{2{b_i[W-1]}}, b_i};
    abs_a = a_i[W-1] ? -a_x : a_x;
    abs_b = b_i[W-1] ? -b_x : b_x;
    mag   = (abs_a < abs_b) ? abs_a : abs_b;
    if (op_i == OP_G) begin
      raw = ps_i ? (b_x - a_x) : (b_x + a_x);
    end else begin
      raw = (a_i[W-1] ^ b_i[W-1]) ? -mag : mag;
    end
    if (raw > SAT_HI) begin
      llr_o = SAT_HI[W-1:0];
    end else if (raw < SAT_LO) begin
      llr_o = SAT_LO[W-1:0];
    end else begin
      llr_o = raw[W-1:0];
    end
  end

endmodule

// File: rtl/polar_line_psum.sv
`timescale 1ns/1ps
module polar_line_psum #(
  parameter int N     = 8,
  parameter int LOG2N = 3,
  parameter int SW    = 2,
  parameter int IW    = 3
) (
  input  logic [N-2:0]   dec_bits_i,
  input  logic [SW-1:0]  stage_i,
  input  logic [IW-1:0]  idx_i,
  output logic [N/2-1:0] ps_o
);

  localparam int P = N / 2;

  logic [P-1:0] ps_by_stage [LOG2N];

  // One re-encoder per stage; the block base is the current index with its
  // lower s+1 bits cleared, which is where the preceding 2^s decisions start.
  for (genvar s = 0; s < LOG2N; s++) begin : g_stage
    localparam int LEN = 1 << s;
    logic [LEN-1:0] blk;
    always_comb begin
      blk = LEN'(dec_bits_i >> ((int'(idx_i) >> (s + 1)) << (s + 1)));
      for (int h = 1; h < LEN; h = h * 2) begin
        for (int j = 0; j < LEN - h; j++) begin
          if ((j & h) == 0) begin
            blk[j] = blk[j] ^ blk[j + h];
          end
        end
      end
      ps_by_stage[s] = P'(blk);
    end
  end

  assign ps_o = ps_by_stage[stage_i];

endmodule

// File: rtl/polar_line_ctrl.sv
`timescale 1ns/1ps
module polar_line_ctrl
  import polar_line_pkg::*;
#(
  parameter int N     = 8,
  parameter int LOG2N = 3,
  parameter int SW    = 2,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [SW-1:0] stage_o,
  output node_op_e      op_o,
  output logic [IW-1:0] idx_o
);

  logic          busy_q, busy_d, done_q, done_d;
  logic [SW-1:0] stage_q, stage_d;
  node_op_e      op_q, op_d;
  logic [IW-1:0] idx_q, idx_d, idx_nxt;

  // Stage at which decoding of bit v begins: its lowest set bit
  function automatic logic [SW-1:0] first_stage(input logic [IW-1:0] v);
    logic [SW-1:0] r;
    r = '0;
    for (int k = IW - 1; k >= 0; k--) begin
      if (v[k]) r = SW'(k);
    end
    return r;
  endfunction

  assign idx_nxt = idx_q + 1'b1;

  always_comb begin
    busy_d  = busy_q;
    stage_d = stage_q;
    op_d    = op_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d  = 1'b1;
        stage_d = SW'(LOG2N - 1);
        op_d    = OP_F;
        idx_d   = '0;
      end
    end else if (stage_q != '0) begin
      stage_d = stage_q - 1'b1;
      op_d    = OP_F;
    end else if (idx_q == IW'(N - 1)) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else begin
      idx_d   = idx_nxt;
      stage_d = first_stage(idx_nxt);
      op_d    = OP_G;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      stage_q <= '0;
      op_q    <= OP_F;
      idx_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      stage_q <= stage_d;
      op_q    <= op_d;
      idx_q   <= idx_d;
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign stage_o = stage_q;
  assign op_o    = op_q;
  assign idx_o   = idx_q;

  // Latency window counter used only by the checks below
  logic [15:0] lat_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt_q <= '0;
    end else if (!busy_q && start_i) begin
      lat_cnt_q <= '0;
    end else if (busy_q) begin
      lat_cnt_q <= lat_cnt_q + 1'b1;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (lat_cnt_q == 16'(2 * N - 2)));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  assert_stage_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (stage_q < SW'(LOG2N)));

endmodule

// File: rtl/polar_line_decoder.sv
`timescale 1ns/1ps
module polar_line_decoder
  import polar_line_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [N*W-1:0] llr_i,
  input  logic [N-1:0] frozen_i,
  output logic [N-1:0] bits_o,
  output logic         done_o,
  output logic         busy_o
);

  localparam int LOG2N = $clog2(N);
  localparam int P     = N / 2;
  localparam int SW    = $clog2(LOG2N + 1);
  localparam int IW    = LOG2N;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic          busy, done, load;
  logic [SW-1:0] stage;
  node_op_e      op;
  logic [IW-1:0] idx;

  polar_line_ctrl #(.N(N), .LOG2N(LOG2N), .SW(SW), .IW(IW)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .busy_o  (busy),
    .done_o  (done),
    .stage_o (stage),
    .op_o    (op),
    .idx_o   (idx)
  );

  assign load = start_i & ~busy;

  // Heap-ordered LLR tree: stage s node j at 2^s + j, channel k at N + k.
  // Stage 0 is decided at once and is not stored.
  logic signed [W-1:0] tree_q [2:2*N-1];
  logic signed [W-1:0] pe_out [P];
  logic [P-1:0]        ps_vec;
  logic [N-1:0]        bits_q, frozen_q;
  logic                dec_bit;

  polar_line_psum #(.N(N), .LOG2N(LOG2N), .SW(SW), .IW(IW)) psum_i (
    .dec_bits_i (bits_q[N-2:0]),
    .stage_i    (stage),
    .idx_i      (idx),
    .ps_o       (ps_vec)
  );

  for (genvar j = 0; j < P; j++) begin : g_lane
    logic signed [W-1:0] a_sel, b_sel;
    always_comb begin
      a_sel = tree_q[(2 << stage) + j];
      b_sel = tree_q[(2 << stage) + (1 << stage) + j];
    end
    polar_line_pe #(.W(W)) pe_i (
      .a_i   (a_sel),
      .b_i   (b_sel),
      .op_i  (op),
      .ps_i  (ps_vec[j]),
      .llr_o (pe_out[j])
    );
  end

  always_ff @(posedge clk) begin
    if (load) begin
      for (int k = 0; k < N; k++) begin
        tree_q[N + k] <= llr_i[k*W +: W];
      end
    end
    if (busy && (stage != '0)) begin
      for (int j = 0; j < P; j++) begin
        if (j < (1 << stage)) begin
          tree_q[(1 << stage) + j] <= pe_out[j];
        end
      end
    end
  end

  assign dec_bit = frozen_q[idx] ? 1'b0 : pe_out[0][W-1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bits_q   <= '0;
      frozen_q <= '0;
    end else if (load) begin
      bits_q   <= '0;
      frozen_q <= frozen_i;
    end else if (busy && (stage == '0)) begin
      bits_q[idx] <= dec_bit;
    end
  end

  assign bits_o = bits_q;
  assign done_o = done;
  assign busy_o = busy;

  assert_frozen_zero_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> ((bits_o & frozen_q) == '0));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && start_i) |=> $stable(frozen_q));

  assert_bits_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && !start_i) |=> $stable(bits_o));

  assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && start_i) |=> (busy_o && (bits_o == '0)));

endmodule

// File: tb/polar_line_decoder_tb_top.sv
`timescale 1ns/1ps
module polar_line_decoder_tb_top;

  localparam int N = 8;
  localparam int W = 6;
  localparam int SATV = 31;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start_i;
  logic [N*W-1:0] llr_i;
  logic [N-1:0]   frozen_i;
  logic [N-1:0]   bits_o;
  logic           done_o, busy_o;

  int tests = 0;
  int fails = 0;
  int dec_time [N] = '{3, 4, 6, 7, 10, 11, 13, 14};

  always #2.5 clk = ~clk;

  polar_line_decoder #(.N(N), .W(W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .llr_i    (llr_i),
    .frozen_i (frozen_i),
    .bits_o   (bits_o),
    .done_o   (done_o),
    .busy_o   (busy_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: min-sum SC for length 8, written out step by step
  function automatic int sat(input int v);
    if (v > SATV) return SATV;
    if (v < -SATV) return -SATV;
    return v;
  endfunction

  function automatic int fmin(input int a, input int b);
    int m;
    m = ((a < 0 ? -a : a) < (b < 0 ? -b : b)) ? (a < 0 ? -a : a) : (b < 0 ? -b : b);
    return sat(((a < 0) != (b < 0)) ? -m : m);
  endfunction

  function automatic int gsum(input int a, input int b, input bit p);
    return sat(p ? b - a : b + a);
  endfunction

  function automatic bit hard(input int l, input bit fz);
    return fz ? 1'b0 : (l < 0);
  endfunction

  function automatic logic [3:0] enc4(input logic [3:0] u);
    return {u[3], u[2] ^ u[3], u[1] ^ u[3], u[0] ^ u[1] ^ u[2] ^ u[3]};
  endfunction

  function automatic logic [7:0] enc8(input logic [7:0] u);
    logic [3:0] hi;
    hi = enc4(u[7:4]);
    return {hi, enc4(u[3:0]) ^ hi};
  endfunction

  function automatic logic [7:0] ref_sc(input int l [8], input logic [7:0] fz);
    int l2 [4];
    int l1 [2];
    int l0;
    logic [7:0] u;
    logic [3:0] v4;
    logic [1:0] v2;
    u = '0;
    for (int j = 0; j < 4; j++) l2[j] = fmin(l[j], l[j+4]);
    for (int j = 0; j < 2; j++) l1[j] = fmin(l2[j], l2[j+2]);
    l0 = fmin(l1[0], l1[1]);        u[0] = hard(l0, fz[0]);
    l0 = gsum(l1[0], l1[1], u[0]);  u[1] = hard(l0, fz[1]);
    v2 = {u[1], u[0] ^ u[1]};
    for (int j = 0; j < 2; j++) l1[j] = gsum(l2[j], l2[j+2], v2[j]);
    l0 = fmin(l1[0], l1[1]);        u[2] = hard(l0, fz[2]);
    l0 = gsum(l1[0], l1[1], u[2]);  u[3] = hard(l0, fz[3]);
    v4 = enc4(u[3:0]);
    for (int j = 0; j < 4; j++) l2[j] = gsum(l[j], l[j+4], v4[j]);
    for (int j = 0; j < 2; j++) l1[j] = fmin(l2[j], l2[j+2]);
    l0 = fmin(l1[0], l1[1]);        u[4] = hard(l0, fz[4]);
    l0 = gsum(l1[0], l1[1], u[4]);  u[5] = hard(l0, fz[5]);
    v2 = {u[5], u[4] ^ u[5]};
    for (int j = 0; j < 2; j++) l1[j] = gsum(l2[j], l2[j+2], v2[j]);
    l0 = fmin(l1[0], l1[1]);        u[6] = hard(l0, fz[6]);
    l0 = gsum(l1[0], l1[1], u[6]);  u[7] = hard(l0, fz[7]);
    return u;
  endfunction

  // One decode, compared against the model on every clock (sampled at negedge)
  task automatic run_case(input int l [8], input logic [7:0] fz, input bit poke,
                          input bit chk_msg, input logic [7:0] msg, input string req);
    logic [7:0] golden, exp_bits;
    golden = ref_sc(l, fz);
    @(negedge clk);
    for (int k = 0; k < N; k++) llr_i[k*W +: W] = W'(l[k]);
    frozen_i = fz;
    start_i  = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t <= 17; t++) begin
      if (t > 0) @(negedge clk);
      exp_bits = '0;
      for (int i = 0; i < N; i++) if (dec_time[i] <= t) exp_bits[i] = golden[i];
      chk(bits_o == exp_bits, (t > 14) ? "R10" : "R8", "bits", bits_o, exp_bits);
      chk(done_o == (t == 14), "R2", "done", done_o, (t == 14));
      chk(busy_o == (t < 14), "R1", "busy", busy_o, (t < 14));
      if (t == 14) chk(bits_o == golden, req, "decoded", bits_o, golden);
      if (poke && t == 5) begin
        start_i  = 1'b1;
        llr_i    = ~llr_i;
        frozen_i = ~fz;
      end
      if (poke && t == 6) begin
        start_i = 1'b0;
        chk(1'b1, "R9", "poke", 0, 0);
      end
    end
    if (chk_msg) chk(bits_o == msg, "R7", "message", bits_o, msg);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int l [8];
    logic [7:0] fz_def, msg, cw;
    fz_def   = 8'b0001_0111;
    rst_n    = 1'b0;
    start_i  = 1'b0;
    llr_i    = '0;
    frozen_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bits_o == '0, "R1", "reset bits", bits_o, 0);
    chk(done_o == 1'b0, "R1", "reset done", done_o, 0);
    chk(busy_o == 1'b0, "R1", "reset busy", busy_o, 0);

    // Noiseless codewords for all information patterns (positions 3,5,6,7)
    for (int m = 0; m < 16; m++) begin
      msg = '0;
      msg[3] = m[0]; msg[5] = m[1]; msg[6] = m[2]; msg[7] = m[3];
      cw = enc8(msg);
      for (int k = 0; k < N; k++) l[k] = cw[k] ? -20 : 20;
      run_case(l, fz_def, 1'b0, 1'b1, msg, "R7");
    end

    // Lightly perturbed, signs intact: message still recovered (min-sum, R5/R6)
    msg = 8'b1010_1000;
    cw  = enc8(msg);
    for (int k = 0; k < N; k++) l[k] = (cw[k] ? -12 : 12) + ((k * 5 + 3) % 7) - 3;
    run_case(l, fz_def, 1'b0, 1'b1, msg, "R5");

    // One weak wrong-sign LLR: compared against the model only
    for (int k = 0; k < N; k++) l[k] = cw[k] ? -9 : 9;
    l[2] = cw[2] ? 2 : -2;
    run_case(l, fz_def, 1'b0, 1'b0, msg, "R5");

    // Extremes drive saturation in f and g (R6), no frozen bits
    l = '{-32, 31, -32, -32, 31, -32, 31, 31};
    run_case(l, 8'h00, 1'b0, 1'b0, msg, "R6");
    l = '{31, 31, -32, 31, -32, -32, 31, -32};
    run_case(l, 8'h00, 1'b0, 1'b0, msg, "R6");

    // Zero LLRs decide 0 on information bits
    l = '{0, 0, 0, 0, 0, 0, 0, 0};
    run_case(l, 8'h00, 1'b0, 1'b1, 8'h00, "R4");

    // All negative, nothing frozen: sign decision
    l = '{-7, -7, -7, -7, -7, -7, -7, -7};
    run_case(l, 8'h00, 1'b0, 1'b0, msg, "R4");

    // All negative, everything frozen: every output bit 0
    run_case(l, 8'hFF, 1'b0, 1'b1, 8'h00, "R3");

    // Start, new LLRs and new mask while busy are ignored
    msg = 8'b0110_1000;
    cw  = enc8(msg);
    for (int k = 0; k < N; k++) l[k] = cw[k] ? -15 : 15;
    run_case(l, fz_def, 1'b1, 1'b1, msg, "R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule